// File: doc/BRIEF.md
# Timer Channel Interrupt Router

This block sits between a bank of timer channels and the interrupt fabric. Each timer channel delivers a one-cycle fire pulse. The router turns that pulse into one of three results. A level-type channel latches a status bit and holds its output line high. An edge-type channel gives a single-cycle pulse on its line. A channel set for message delivery issues a single-cycle memory-write strobe and drives no line. Each channel has a route field that picks its output line. Software clears latched status by writing ones to the status register.

A legacy mode overrides the routes of the first two channels. In that mode channel 0 is tied to line 0 and channel 1 to line 8. Line 8 normally carries an external real-time-clock interrupt input straight through. In legacy mode line 8 belongs to channel 1, and the real-time-clock input is masked. Clearing legacy mode returns line 8 to the live level of that input. The main counter and the comparators are outside this block. It only routes and records what the channels report.

Top module: `tirq_router`

## Requirements
- R1: While reset is asserted, every status bit is 0, the message strobe is 0, and every line is 0 except line 8, which follows the real-time-clock input.
- R2: Outside legacy mode, an active channel drives the line whose index equals its route field. A route value at or above the number of lines drives no line.
- R3: In legacy mode, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold. Channels 2 and up keep their route fields.
- R4: A fire on an enabled level-type channel (level select = 1) sets its status bit in the next cycle. The routed line then stays high until the bit is cleared.
- R5: A fire on an enabled edge-type channel (level select = 0) raises its line for exactly one cycle and leaves its status bit at 0.
- R6: A status write clears each status bit whose write-data bit is 1, and the matching line falls. A fire on the same channel in the same cycle takes priority, so the bit stays set.
- R7: When the channel enable or the global enable is 0, the channel's status bit is cleared in the next cycle, its line is low, and fires on it are ignored.
- R8: A fire on an enabled channel with message delivery on gives a one-cycle strobe in the next cycle. The strobe carries address = bits 63:32 and data = bits 31:0 of that channel's 64-bit message route. The channel drives no line and its status bit does not change. When several channels request a message in the same cycle, the lowest-numbered one wins.
- R9: Line 8 carries the real-time-clock input while legacy mode is off. Entering legacy mode masks the input at once, and leaving legacy mode restores its current level.
- R10: Channels that share a line are ORed together. The line stays high while any of them still has a contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glob_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy routing mode |
| rtc_irq_i | input | 1 | Real-time-clock interrupt, passed through to line 8 |
| ch_en_i | input | N_CH | Per-channel enable |
| ch_level_i | input | N_CH | 1 = level type, 0 = edge type |
| ch_msg_en_i | input | N_CH | Per-channel message delivery enable |
| ch_route_i | input | N_CH*RTE_W | Route fields, channel c at bits [c*RTE_W +: RTE_W] |
| ch_msg_route_i | input | N_CH*64 | Message routes, channel c at bits [c*64 +: 64] |
| fire_i | input | N_CH | One-cycle fire pulses from the timer channels |
| sts_wr_i | input | 1 | Status register write strobe |
| sts_wdata_i | input | N_CH | Status write data, write-one-to-clear |
| sts_o | output | N_CH | Latched per-channel status |
| irq_o | output | N_LINES | Output interrupt lines |
| msg_valid_o | output | 1 | Message write strobe |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
The bench builds the router with 4 channels, 12 lines and 4-bit route fields. Route values 12 to 15 therefore exist but name no line, which makes the dropped-route case of R2 reachable. Four channels are enough to cover both legacy overrides, two routed channels that share a line, and two message requests in the same cycle. The bench runs a behavioural model beside the design and compares every output on every clock. Directed checks then cover each corner: a clear and a fire in the same cycle, reconfiguring a channel while its status bit is set, and toggling legacy mode while the real-time-clock input is high.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned LEG_LINE_CH0 = 0;
  localparam int unsigned LEG_LINE_CH1 = 8;
  localparam int unsigned RTC_LINE     = 8;
  localparam int unsigned MROUTE_W     = 64;
  localparam int unsigned MADDR_W      = 32;
  localparam int unsigned MDATA_W      = 32;
endpackage

// File: rtl/tirq_sts_bank.sv
module tirq_sts_bank #(
  parameter int unsigned N_CH = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] fire_i,
  input  logic [N_CH-1:0] act_i,
  input  logic [N_CH-1:0] level_i,
  input  logic [N_CH-1:0] msg_en_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] sts_o,
  output logic [N_CH-1:0] pulse_o
);
  logic [N_CH-1:0] sts_q, pulse_q, set_w, edge_w;

  assign set_w  = fire_i & act_i & level_i & ~msg_en_i;
  assign edge_w = fire_i & act_i & ~level_i & ~msg_en_i;

  // fire beats clear; an edge fire drops any stale level status
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_q   <= '0;
      pulse_q <= '0;
    end else begin
      sts_q   <= ((sts_q & ~clr_i & ~edge_w) | set_w) & act_i;
      pulse_q <= edge_w;
    end
  end

  assign sts_o   = sts_q;
  assign pulse_o = pulse_q;

  a_r4_level_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_w) |=> ((sts_o & $past(set_w)) == $past(set_w)));
  a_r5_edge_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_w) |=> (((sts_o & $past(edge_w)) == '0) && ((pulse_o & $past(edge_w)) == $past(edge_w))));
  a_r7_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |=> (sts_o == '0 && pulse_o == '0));
endmodule

// File: rtl/tirq_line_map.sv
module tirq_line_map #(
  parameter int unsigned N_CH    = 32,
  parameter int unsigned N_LINES = 32,
  parameter int unsigned RTE_W   = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  legacy_i,
  input  logic                  rtc_i,
  input  logic [N_CH-1:0]       drive_i,
  input  logic [N_CH*RTE_W-1:0] route_i,
  output logic [N_LINES-1:0]    line_o
);
  import tirq_pkg::*;

  always_comb begin
    line_o = '0;
    for (int c = 0; c < int'(N_CH); c++) begin
      if (drive_i[c]) begin
        if (legacy_i && c == 0) begin
          line_o[LEG_LINE_CH0] = 1'b1;
        end else if (legacy_i && c == 1) begin
          line_o[LEG_LINE_CH1] = 1'b1;
        end else begin
          for (int l = 0; l < int'(N_LINES); l++) begin
            if (int'(route_i[c*RTE_W +: RTE_W]) == l) line_o[l] = 1'b1;
          end
        end
      end
    end
    if (!legacy_i && rtc_i) line_o[RTC_LINE] = 1'b1;
  end

  a_r3_legacy_ch0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_i && drive_i[0]) |-> line_o[LEG_LINE_CH0]);
  a_r9_rtc_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legacy_i && rtc_i) |-> line_o[RTC_LINE]);
endmodule

// File: rtl/tirq_msg_pick.sv
module tirq_msg_pick #(
  parameter int unsigned N_CH = 32
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_CH-1:0]                       req_i,
  input  logic [N_CH*tirq_pkg::MROUTE_W-1:0]    mroute_i,
  output logic                                  valid_o,
  output logic [tirq_pkg::MADDR_W-1:0]          addr_o,
  output logic [tirq_pkg::MDATA_W-1:0]          data_o
);
  import tirq_pkg::*;

  logic [MROUTE_W-1:0] pick_w;
  logic                valid_q;
  logic [MROUTE_W-1:0] word_q;

  // lowest index wins
  always_comb begin
    pick_w = '0;
    for (int c = int'(N_CH) - 1; c >= 0; c--) begin
      if (req_i[c]) pick_w = mroute_i[c*MROUTE_W +: MROUTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      word_q  <= '0;
    end else begin
      valid_q <= |req_i;
      if (|req_i) word_q <= pick_w;
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = word_q[MROUTE_W-1 -: MADDR_W];
  assign data_o  = word_q[MDATA_W-1:0];

  a_r8_strobe_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> valid_o);
  a_r8_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> !valid_o);
endmodule

// File: rtl/tirq_router.sv
module tirq_router #(
  parameter int unsigned N_CH    = 32,
  parameter int unsigned N_LINES = 32,
  parameter int unsigned RTE_W   = 5
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 glob_en_i,
  input  logic                                 legacy_i,
  input  logic                                 rtc_irq_i,
  input  logic [N_CH-1:0]                      ch_en_i,
  input  logic [N_CH-1:0]                      ch_level_i,
  input  logic [N_CH-1:0]                      ch_msg_en_i,
  input  logic [N_CH*RTE_W-1:0]                ch_route_i,
  input  logic [N_CH*tirq_pkg::MROUTE_W-1:0]   ch_msg_route_i,
  input  logic [N_CH-1:0]                      fire_i,
  input  logic                                 sts_wr_i,
  input  logic [N_CH-1:0]                      sts_wdata_i,
  output logic [N_CH-1:0]                      sts_o,
  output logic [N_LINES-1:0]                   irq_o,
  output logic                                 msg_valid_o,
  output logic [tirq_pkg::MADDR_W-1:0]         msg_addr_o,
  output logic [tirq_pkg::MDATA_W-1:0]         msg_data_o
);
  logic [N_CH-1:0] act_w, clr_w, pulse_w, drive_w, req_w;

  assign act_w   = glob_en_i ? ch_en_i : '0;
  assign clr_w   = sts_wr_i ? sts_wdata_i : '0;
  assign req_w   = fire_i & act_w & ch_msg_en_i;
  assign drive_w = (sts_o | pulse_w) & ~ch_msg_en_i;

  tirq_sts_bank #(.N_CH(N_CH)) u_sts (
    .clk_i, .rst_ni,
    .fire_i   (fire_i),
    .act_i    (act_w),
    .level_i  (ch_level_i),
    .msg_en_i (ch_msg_en_i),
    .clr_i    (clr_w),
    .sts_o    (sts_o),
    .pulse_o  (pulse_w)
  );

  tirq_line_map #(.N_CH(N_CH), .N_LINES(N_LINES), .RTE_W(RTE_W)) u_map (
    .clk_i, .rst_ni,
    .legacy_i (legacy_i),
    .rtc_i    (rtc_irq_i),
    .drive_i  (drive_w),
    .route_i  (ch_route_i),
    .line_o   (irq_o)
  );

  tirq_msg_pick #(.N_CH(N_CH)) u_msg (
    .clk_i, .rst_ni,
    .req_i    (req_w),
    .mroute_i (ch_msg_route_i),
    .valid_o  (msg_valid_o),
    .addr_o   (msg_addr_o),
    .data_o   (msg_data_o)
  );

  a_r6_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr_i && ((sts_wdata_i & ~fire_i) != '0)) |=> ((sts_o & $past(sts_wdata_i & ~fire_i)) == '0));
endmodule

// File: tb/tb_tirq_router.sv
module tb_tirq_router;
  localparam int NC = 4;
  localparam int NL = 12;
  localparam int RW = 4;

  logic clk = 0, rst_n = 0;
  logic glob_en = 0, legacy = 0, rtc = 0, sts_wr = 0;
  logic [NC-1:0] ch_en = 0, ch_level = 0, ch_msg_en = 0, fire = 0, sts_wdata = 0;
  logic [NC*RW-1:0] route = 0;
  logic [NC*64-1:0] mroute = 0;
  logic [NC-1:0] sts;
  logic [NL-1:0] irq;
  logic mv;
  logic [31:0] ma, md;

  tirq_router #(.N_CH(NC), .N_LINES(NL), .RTE_W(RW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .glob_en_i(glob_en), .legacy_i(legacy),
    .rtc_irq_i(rtc), .ch_en_i(ch_en), .ch_level_i(ch_level), .ch_msg_en_i(ch_msg_en),
    .ch_route_i(route), .ch_msg_route_i(mroute), .fire_i(fire), .sts_wr_i(sts_wr),
    .sts_wdata_i(sts_wdata), .sts_o(sts), .irq_o(irq), .msg_valid_o(mv),
    .msg_addr_o(ma), .msg_data_o(md));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_sts[NC];
  bit m_pulse[NC];
  bit m_mv;
  logic [63:0] m_word;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_sts[c]) begin m_sts[c] <= 0; m_pulse[c] <= 0; end
      m_mv <= 0; m_word <= 0;
    end else begin
      bit found;
      found = 0;
      for (int c = 0; c < NC; c++) begin
        bit on;
        on = glob_en && ch_en[c];
        m_pulse[c] <= on && fire[c] && !ch_msg_en[c] && !ch_level[c];
        if (!on) m_sts[c] <= 0;
        else if (fire[c] && !ch_msg_en[c]) m_sts[c] <= ch_level[c];
        else if (sts_wr && sts_wdata[c]) m_sts[c] <= 0;
        if (on && fire[c] && ch_msg_en[c] && !found) begin
          found = 1;
          m_word <= mroute[c*64 +: 64];
        end
      end
      m_mv <= found;
    end
  end

  function automatic logic [NL-1:0] exp_lines();
    logic [NL-1:0] e = '0;
    for (int c = 0; c < NC; c++) begin
      if ((m_sts[c] || m_pulse[c]) && !ch_msg_en[c]) begin
        int t;
        if (legacy && c == 0) t = 0;
        else if (legacy && c == 1) t = 8;
        else t = int'(route[c*RW +: RW]);
        if (t < NL) e[t] = 1;
      end
    end
    if (!legacy && rtc) e[8] = 1;
    return e;
  endfunction

  function automatic logic [NC-1:0] exp_sts();
    logic [NC-1:0] e;
    for (int c = 0; c < NC; c++) e[c] = m_sts[c];
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk({cur_req, " sts"}, 64'(sts), 64'(exp_sts()));
    chk({cur_req, " irq"}, 64'(irq), 64'(exp_lines()));
    chk({cur_req, " msg_valid"}, 64'(mv), 64'(m_mv));
    if (m_mv) chk({cur_req, " msg_word"}, {ma, md}, m_word);
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
      cmp_all();
    end
  endtask

  task automatic clear_all();
    fire = 0; sts_wr = 1; sts_wdata = '1; tick(); sts_wr = 0; sts_wdata = 0; tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1 reset
    rtc = 1;
    tick(2);
    chk("R1 sts in reset", 64'(sts), 0);
    chk("R1 irq in reset", 64'(irq), 64'(1) << 8);
    chk("R1 msg in reset", 64'(mv), 0);
    rtc = 0;
    rst_n = 1;
    tick();

    // ch0 level r3, ch1 edge r5, ch2 level r14 (dropped), ch3 level r3
    glob_en = 1; ch_en = '1; ch_level = 4'b1101;
    route = {4'd3, 4'd14, 4'd5, 4'd3};
    mroute = {64'hA3A3_0003_D3D3_0003, 64'hA2A2_0002_D2D2_0002,
              64'hA1A1_0001_D1D1_0001, 64'hA0A0_0000_D0D0_0000};

    cur_req = "R4";
    fire = 4'b0001; tick(); fire = 0;
    chk("R4 sts set", 64'(sts[0]), 1);
    chk("R4 line up", 64'(irq[3]), 1);
    tick(3);
    chk("R4 line held", 64'(irq[3]), 1);

    cur_req = "R6";
    sts_wr = 1; sts_wdata = 4'b0001; tick(); sts_wr = 0; sts_wdata = 0;
    chk("R6 cleared", 64'(sts[0]), 0);
    chk("R6 line down", 64'(irq[3]), 0);

    cur_req = "R5";
    fire = 4'b0010; tick(); fire = 0;
    chk("R5 pulse", 64'(irq[5]), 1);
    chk("R5 no sts", 64'(sts[1]), 0);
    tick();
    chk("R5 one cycle", 64'(irq[5]), 0);

    cur_req = "R2";
    fire = 4'b0100; tick(); fire = 0;
    chk("R2 sts out-of-range route", 64'(sts[2]), 1);
    chk("R2 no line", 64'(irq), 0);
    route[0 +: RW] = 4'd7; fire = 4'b0001; tick(); fire = 0;
    chk("R2 route 7", 64'(irq[7]), 1);
    clear_all();
    route[0 +: RW] = 4'd3;

    cur_req = "R10";
    fire = 4'b1001; tick(); fire = 0;
    sts_wr = 1; sts_wdata = 4'b0001; tick(); sts_wr = 0; sts_wdata = 0;
    chk("R10 shared stays", 64'(irq[3]), 1);
    sts_wr = 1; sts_wdata = 4'b1000; tick(); sts_wr = 0; sts_wdata = 0;
    chk("R10 shared drops", 64'(irq[3]), 0);

    cur_req = "R6";
    fire = 4'b0001; tick();
    sts_wr = 1; sts_wdata = 4'b1001; tick(); sts_wr = 0; sts_wdata = 0; fire = 0;
    chk("R6 fire beats clear", 64'(sts[0]), 1);
    ch_level[0] = 0; fire = 4'b0001; tick(); fire = 0;
    chk("R5 edge fire clears stale sts", 64'(sts[0]), 0);
    ch_level[0] = 1;
    clear_all();

    cur_req = "R3";
    legacy = 1;
    fire = 4'b0011; tick(); fire = 0;
    chk("R3 ch0 to line0", 64'(irq[0]), 1);
    chk("R3 ch1 to line8", 64'(irq[8]), 1);
    chk("R3 route ignored", 64'(irq[3]), 0);
    tick();
    chk("R3 ch1 pulse ends", 64'(irq[8]), 0);
    clear_all();

    cur_req = "R9";
    rtc = 1; tick();
    chk("R9 masked in legacy", 64'(irq[8]), 0);
    legacy = 0; tick();
    chk("R9 restored", 64'(irq[8]), 1);
    legacy = 1; tick();
    chk("R9 lowered on entry", 64'(irq[8]), 0);
    legacy = 0; rtc = 0; tick();

    cur_req = "R7";
    fire = 4'b0001; tick(); fire = 0;
    ch_en[0] = 0; tick();
    chk("R7 ch disable clears", 64'(sts[0]), 0);
    chk("R7 line low", 64'(irq[3]), 0);
    fire = 4'b0001; tick(); fire = 0;
    chk("R7 fire ignored", 64'(sts[0]), 0);
    ch_en[0] = 1;
    fire = 4'b1000; tick(); fire = 0;
    glob_en = 0; tick();
    chk("R7 global disable clears", 64'(sts[3]), 0);
    fire = 4'b1000; tick(); fire = 0;
    chk("R7 global fire ignored", 64'(irq), 0);
    glob_en = 1; tick();

    cur_req = "R8";
    fire = 4'b0001; tick(); fire = 0;
    ch_msg_en = 4'b1100;
    fire = 4'b1100; tick(); fire = 0;
    chk("R8 strobe", 64'(mv), 1);
    chk("R8 lowest wins", {ma, md}, 64'hA2A2_0002_D2D2_0002);
    chk("R8 no line", 64'(irq & ~(12'h1 << 3)), 0);
    chk("R8 sts untouched", 64'(sts), 1);
    tick();
    chk("R8 one cycle", 64'(mv), 0);
    fire = 4'b1000; tick(); fire = 0;
    chk("R8 single", {ma, md}, 64'hA3A3_0003_D3D3_0003);
    glob_en = 0; fire = 4'b1000; tick(); fire = 0;
    chk("R8 disabled no strobe", 64'(mv), 0);
    glob_en = 1; ch_msg_en = 0;
    clear_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule